// File: doc/BRIEF.md
# Transaction Sequence Trigger Monitor

This block observes three handshake probes, a request, an acknowledge and a grant, and recognises one ordered transaction: request first, then acknowledge, then grant. Each step may arrive any number of cycles after the one before it. When a grant completes the sequence, the block emits a one-cycle trigger pulse that a signal capture unit uses to begin or end recording. A mode input decides which of those two meanings the pulse has.

Every completed transaction also updates a set of statistics. A saturating transaction counter advances by one. The latency of the transaction is stored, counted from the request cycle to the grant cycle. A running maximum of those latencies is kept. A programmable timeout drops a stalled sequence and raises a sticky abort flag. A synchronous clear zeroes all statistics and the abort flag.

Top module: `txn_seq_trigger`

## Requirements
- R1: After reset the trigger outputs, abort flag, count, last latency and maximum latency are all zero.
- R2: A request, then an acknowledge on a later cycle, then a grant on a later cycle, completes a transaction. The trigger is high for exactly the one cycle after the clock edge that samples the grant.
- R3: With `stop_mode_i` low at the grant, the pulse appears on `trig_start_o`; with it high, the pulse appears on `trig_stop_o`. The two triggers are never high together.
- R4: A grant seen while waiting for the acknowledge returns the monitor to idle without a trigger. An acknowledge or grant seen while idle is ignored.
- R5: With `timeout_i` = T > 0, if the next step is absent for T consecutive cycles after the previous step, the monitor returns to idle and `abort_o` becomes 1 and stays 1 until a clear. A step arriving on the T-th cycle is still accepted.
- R6: `timeout_i` = 0 disables the timeout, so a sequence may wait indefinitely.
- R7: `count_o` increases by one per completed transaction and holds at its all-ones value instead of wrapping.
- R8: The latency of a transaction is the number of cycles from the request cycle to the grant cycle. Back-to-back steps give 2. The value is presented on `last_lat_o`.
- R9: `max_lat_o` holds the largest latency since the last clear or reset, and a smaller latency does not lower it.
- R10: A latency larger than the all-ones value of the latency width is reported as that all-ones value.
- R11: `clear_i` zeroes count, last latency, maximum latency and abort flag on the next edge. A clear that coincides with a completion wins over the statistics update, but the trigger pulse is still produced.
- R12: While `enable_i` is low the monitor is held idle: no trigger, no count, and a partly seen sequence is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Monitor enable |
| stop_mode_i | input | 1 | 0: pulse means start capture, 1: pulse means stop capture |
| clear_i | input | 1 | Synchronous clear of statistics and abort flag |
| timeout_i | input | TO_W | Allowed wait per step in cycles, 0 = no limit |
| req_i | input | 1 | Request probe |
| ack_i | input | 1 | Acknowledge probe |
| gnt_i | input | 1 | Grant probe |
| trig_start_o | output | 1 | One-cycle start-capture pulse |
| trig_stop_o | output | 1 | One-cycle stop-capture pulse |
| abort_o | output | 1 | Sticky timeout abort flag |
| count_o | output | CNT_W | Saturating completed-transaction count |
| last_lat_o | output | LAT_W | Latency of the most recent transaction |
| max_lat_o | output | LAT_W | Largest latency seen |

## Verification
A completion and a clear can land on the same edge. The bench provokes this by driving `clear_i` during the grant cycle of a sequence that follows earlier completions. It expects the trigger pulse to appear while count, last latency and maximum latency all read zero. A second coincidence tests the timeout boundary: an acknowledge arrives on the very cycle the wait limit expires, and the bench requires that it advances the sequence rather than aborting it.

// File: rtl/txn_seq_pkg.sv
package txn_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_ACK = 2'd1,
        ST_WAIT_GNT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/txn_seq_fsm.sv
module txn_seq_fsm
    import txn_seq_pkg::*;
#(
    parameter int TO_W  = 8,
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [TO_W-1:0]  timeout_i,
    input  logic             req_i,
    input  logic             ack_i,
    input  logic             gnt_i,
    output logic             done_o,
    output logic [LAT_W-1:0] done_lat_o,
    output logic             abort_o
);

    localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};

    typedef struct packed {
        seq_state_e       st;
        logic [TO_W-1:0]  wait_cnt;
        logic [LAT_W-1:0] lat;
    } fsm_regs_t;

    fsm_regs_t q, d;
    logic [LAT_W-1:0] lat_inc;
    logic             timed_out;

    always_comb begin
        d         = q;
        done_o    = 1'b0;
        abort_o   = 1'b0;
        lat_inc   = (q.lat == LAT_MAX) ? q.lat : q.lat + LAT_W'(1);
        timed_out = (timeout_i != '0) && (q.wait_cnt == timeout_i - TO_W'(1));

        case (q.st)
            ST_IDLE: begin
                if (req_i) begin
                    d.st       = ST_WAIT_ACK;
                    d.wait_cnt = '0;
                    d.lat      = LAT_W'(1);
                end
            end
            ST_WAIT_ACK: begin
                d.lat = lat_inc;
                if (ack_i) begin
                    d.st       = ST_WAIT_GNT;
                    d.wait_cnt = '0;
                end else if (gnt_i) begin
                    d.st = ST_IDLE;
                end else if (timed_out) begin
                    d.st    = ST_IDLE;
                    abort_o = 1'b1;
                end else begin
                    d.wait_cnt = q.wait_cnt + TO_W'(1);
                end
            end
            ST_WAIT_GNT: begin
                d.lat = lat_inc;
                if (gnt_i) begin
                    d.st   = ST_IDLE;
                    done_o = 1'b1;
                end else if (timed_out) begin
                    d.st    = ST_IDLE;
                    abort_o = 1'b1;
                end else begin
                    d.wait_cnt = q.wait_cnt + TO_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (!enable_i) begin
            d.st    = ST_IDLE;
            done_o  = 1'b0;
            abort_o = 1'b0;
        end
    end

    assign done_lat_o = q.lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.wait_cnt <= '0;
            q.lat      <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/txn_seq_stats.sv
module txn_seq_stats #(
    parameter int CNT_W = 16,
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             stop_mode_i,
    input  logic             done_i,
    input  logic [LAT_W-1:0] done_lat_i,
    input  logic             abort_i,
    output logic             trig_start_o,
    output logic             trig_stop_o,
    output logic             abort_flag_o,
    output logic [CNT_W-1:0] count_o,
    output logic [LAT_W-1:0] last_lat_o,
    output logic [LAT_W-1:0] max_lat_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             trig_start;
        logic             trig_stop;
        logic             abort_flag;
        logic [CNT_W-1:0] count;
        logic [LAT_W-1:0] last_lat;
        logic [LAT_W-1:0] max_lat;
    } stat_regs_t;

    stat_regs_t q, d;

    always_comb begin
        d            = q;
        d.trig_start = done_i & ~stop_mode_i;
        d.trig_stop  = done_i & stop_mode_i;
        if (done_i) begin
            if (q.count != CNT_MAX) begin
                d.count = q.count + CNT_W'(1);
            end
            d.last_lat = done_lat_i;
            if (done_lat_i > q.max_lat) begin
                d.max_lat = done_lat_i;
            end
        end
        if (abort_i) begin
            d.abort_flag = 1'b1;
        end
        if (clear_i) begin
            d.count      = '0;
            d.last_lat   = '0;
            d.max_lat    = '0;
            d.abort_flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign trig_start_o = q.trig_start;
    assign trig_stop_o  = q.trig_stop;
    assign abort_flag_o = q.abort_flag;
    assign count_o      = q.count;
    assign last_lat_o   = q.last_lat;
    assign max_lat_o    = q.max_lat;

endmodule

// File: rtl/txn_seq_trigger.sv
module txn_seq_trigger #(
    parameter int TO_W  = 8,
    parameter int CNT_W = 16,
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             stop_mode_i,
    input  logic             clear_i,
    input  logic [TO_W-1:0]  timeout_i,
    input  logic             req_i,
    input  logic             ack_i,
    input  logic             gnt_i,
    output logic             trig_start_o,
    output logic             trig_stop_o,
    output logic             abort_o,
    output logic [CNT_W-1:0] count_o,
    output logic [LAT_W-1:0] last_lat_o,
    output logic [LAT_W-1:0] max_lat_o
);

    logic             seq_done;
    logic             seq_abort;
    logic [LAT_W-1:0] seq_lat;

    txn_seq_fsm #(
        .TO_W  (TO_W),
        .LAT_W (LAT_W)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .timeout_i  (timeout_i),
        .req_i      (req_i),
        .ack_i      (ack_i),
        .gnt_i      (gnt_i),
        .done_o     (seq_done),
        .done_lat_o (seq_lat),
        .abort_o    (seq_abort)
    );

    txn_seq_stats #(
        .CNT_W (CNT_W),
        .LAT_W (LAT_W)
    ) stats_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear_i),
        .stop_mode_i  (stop_mode_i),
        .done_i       (seq_done),
        .done_lat_i   (seq_lat),
        .abort_i      (seq_abort),
        .trig_start_o (trig_start_o),
        .trig_stop_o  (trig_stop_o),
        .abort_flag_o (abort_o),
        .count_o      (count_o),
        .last_lat_o   (last_lat_o),
        .max_lat_o    (max_lat_o)
    );

endmodule

// File: rtl/txn_seq_trigger_chk.sv
module txn_seq_trigger_chk #(
    parameter int CNT_W = 16,
    parameter int LAT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable_i,
    input logic             clear_i,
    input logic             trig_start_o,
    input logic             trig_stop_o,
    input logic             abort_o,
    input logic [CNT_W-1:0] count_o,
    input logic [LAT_W-1:0] last_lat_o,
    input logic [LAT_W-1:0] max_lat_o
);

    p_one_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(trig_start_o && trig_stop_o));

    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_start_o || trig_stop_o) |=> !(trig_start_o || trig_stop_o));

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |-> ((count_o == $past(count_o) + CNT_W'(1)) || (count_o == '0)));

    p_max_ge_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        max_lat_o >= last_lat_o);

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_o == '0 && last_lat_o == '0 && max_lat_o == '0 && !abort_o));

    p_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !(trig_start_o || trig_stop_o));

endmodule

bind txn_seq_trigger txn_seq_trigger_chk #(
    .CNT_W (CNT_W),
    .LAT_W (LAT_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .clear_i      (clear_i),
    .trig_start_o (trig_start_o),
    .trig_stop_o  (trig_stop_o),
    .abort_o      (abort_o),
    .count_o      (count_o),
    .last_lat_o   (last_lat_o),
    .max_lat_o    (max_lat_o)
);

// File: tb/txn_seq_trigger_tb_top.sv
module txn_seq_trigger_tb_top;

    localparam int TO_W   = 8;
    localparam int CNT_W  = 4;
    localparam int LAT_W  = 4;
    localparam int CLK_NS = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable_i = 1'b1;
    logic             stop_mode_i = 1'b0;
    logic             clear_i = 1'b0;
    logic [TO_W-1:0]  timeout_i = 8'd20;
    logic             req_i = 1'b0;
    logic             ack_i = 1'b0;
    logic             gnt_i = 1'b0;
    logic             trig_start_o, trig_stop_o, abort_o;
    logic [CNT_W-1:0] count_o;
    logic [LAT_W-1:0] last_lat_o, max_lat_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_NS/2) clk = ~clk;

    txn_seq_trigger #(.TO_W(TO_W), .CNT_W(CNT_W), .LAT_W(LAT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .stop_mode_i(stop_mode_i),
        .clear_i(clear_i), .timeout_i(timeout_i), .req_i(req_i), .ack_i(ack_i),
        .gnt_i(gnt_i), .trig_start_o(trig_start_o), .trig_stop_o(trig_stop_o),
        .abort_o(abort_o), .count_o(count_o), .last_lat_o(last_lat_o),
        .max_lat_o(max_lat_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic r, input logic a, input logic g);
        @(negedge clk);
        req_i = r; ack_i = a; gnt_i = g;
        @(posedge clk);
        #1;
    endtask

    // latency = gap1 + gap2 + 2
    task automatic run_seq(input int gap1, input int gap2);
        cyc(1, 0, 0);
        repeat (gap1) cyc(0, 0, 0);
        cyc(0, 1, 0);
        repeat (gap2) cyc(0, 0, 0);
        cyc(0, 0, 1);
    endtask

    task automatic t_reset;
        check("R1 trig_start", trig_start_o, 0);
        check("R1 trig_stop", trig_stop_o, 0);
        check("R1 abort", abort_o, 0);
        check("R1 count", count_o, 0);
        check("R1 last", last_lat_o, 0);
        check("R1 max", max_lat_o, 0);
    endtask

    task automatic t_basic;
        run_seq(2, 3);
        check("R2 trig_start pulse", trig_start_o, 1);
        check("R3 trig_stop quiet", trig_stop_o, 0);
        check("R7 count", count_o, 1);
        check("R8 last latency", last_lat_o, 7);
        check("R9 max latency", max_lat_o, 7);
        cyc(0, 0, 0);
        check("R2 pulse ends", trig_start_o, 0);
    endtask

    task automatic t_adjacent;
        run_seq(0, 0);
        check("R8 adjacent latency", last_lat_o, 2);
        check("R9 max kept", max_lat_o, 7);
        check("R7 count", count_o, 2);
        cyc(0, 0, 0);
    endtask

    task automatic t_stop_mode;
        stop_mode_i = 1'b1;
        run_seq(1, 0);
        check("R3 trig_stop pulse", trig_stop_o, 1);
        check("R3 trig_start quiet", trig_start_o, 0);
        check("R8 latency", last_lat_o, 3);
        cyc(0, 0, 0);
        check("R3 stop pulse ends", trig_stop_o, 0);
        stop_mode_i = 1'b0;
    endtask

    task automatic t_out_of_order;
        cyc(1, 0, 0);
        cyc(0, 0, 1);
        check("R4 early grant no trig", int'(trig_start_o | trig_stop_o), 0);
        cyc(0, 1, 0);
        cyc(0, 0, 1);
        check("R4 idle ack/grant ignored", int'(trig_start_o | trig_stop_o), 0);
        check("R4 count unchanged", count_o, 3);
    endtask

    task automatic t_timeout;
        timeout_i = 8'd4;
        cyc(1, 0, 0);
        repeat (3) cyc(0, 0, 0);
        check("R5 no abort before limit", abort_o, 0);
        cyc(0, 0, 0);
        check("R5 abort at limit", abort_o, 1);
        cyc(0, 1, 0);
        cyc(0, 0, 1);
        check("R5 aborted seq no trig", trig_start_o, 0);
        check("R5 abort sticky", abort_o, 1);
        run_seq(3, 0);
        check("R5 step on last allowed cycle", trig_start_o, 1);
        check("R5 latency", last_lat_o, 5);
        check("R7 count", count_o, 4);
        cyc(0, 0, 0);
    endtask

    task automatic t_clear;
        @(negedge clk);
        clear_i = 1'b1;
        @(posedge clk);
        #1;
        clear_i = 1'b0;
        check("R11 count cleared", count_o, 0);
        check("R11 last cleared", last_lat_o, 0);
        check("R11 max cleared", max_lat_o, 0);
        check("R11 abort cleared", abort_o, 0);
    endtask

    task automatic t_clear_collide;
        run_seq(0, 1);
        check("R7 count after clear", count_o, 1);
        cyc(1, 0, 0);
        cyc(0, 1, 0);
        @(negedge clk);
        req_i = 0; ack_i = 0; gnt_i = 1; clear_i = 1;
        @(posedge clk);
        #1;
        clear_i = 1'b0;
        check("R11 trigger still fires", trig_start_o, 1);
        check("R11 clear wins count", count_o, 0);
        check("R11 clear wins last", last_lat_o, 0);
        check("R11 clear wins max", max_lat_o, 0);
        cyc(0, 0, 0);
    endtask

    task automatic t_no_timeout_sat;
        timeout_i = 8'd0;
        cyc(1, 0, 0);
        repeat (30) cyc(0, 0, 0);
        check("R6 no abort with zero timeout", abort_o, 0);
        cyc(0, 1, 0);
        cyc(0, 0, 1);
        check("R6 late sequence completes", trig_start_o, 1);
        check("R10 latency saturates", last_lat_o, 15);
        check("R10 max saturates", max_lat_o, 15);
        cyc(0, 0, 0);
    endtask

    task automatic t_count_sat;
        t_clear;
        for (int i = 0; i < 17; i++) begin
            run_seq(0, 0);
        end
        check("R7 count saturates", count_o, 15);
        cyc(0, 0, 0);
    endtask

    task automatic t_enable;
        t_clear;
        enable_i = 1'b0;
        run_seq(0, 0);
        check("R12 disabled no trig", trig_start_o, 0);
        check("R12 disabled no count", count_o, 0);
        enable_i = 1'b1;
        cyc(1, 0, 0);
        cyc(0, 1, 0);
        enable_i = 1'b0;
        cyc(0, 0, 0);
        enable_i = 1'b1;
        cyc(0, 0, 1);
        check("R12 dropped seq no trig", trig_start_o, 0);
        check("R12 dropped seq no count", count_o, 0);
    endtask

    initial begin
        #(CLK_NS * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        t_basic;
        t_adjacent;
        t_stop_mode;
        t_out_of_order;
        t_timeout;
        t_clear;
        t_clear_collide;
        t_no_timeout_sat;
        t_count_sat;
        t_enable;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule